// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a countdown timer that sits on a plain 32-bit register bus. Software programs a start value, a divide ratio and a few mode bits. The live counter then steps down once per prescaler tick. When it arrives at zero it latches a sticky event flag. It then either stays at zero or refills itself from the programmed start value, so it can serve as a one-shot delay or as a periodic interval source.

A level interrupt line reports the event flag whenever interrupts are enabled. Software acknowledges the event by writing a one to the flag. A write of the start value also presets the live counter at once, so a new interval can begin in the middle of a run without first stopping the timer.

Top module: `cdt_timer`

## Requirements
- R1: Bus decode uses byte offsets 0x00 (start value, read/write), 0x04 (live count, read-only, writes ignored), 0x08 (control) and 0x0C (event status). A read at any other offset returns zero.
- R2: A write to offset 0x00 stores the value and presets the live counter with it at the same clock edge. It also restarts the prescaler phase.
- R3: While control bit 0 is set, the counter decrements once every P+1 clocks, where P is control bits 15:8. The first decrement lands P+1 clocks after the write that sets bit 0. While bit 0 is clear, the count holds.
- R4: With control bit 1 clear, a tick at zero leaves the counter at zero and raises no further event.
- R5: With control bit 1 set, a tick at zero refills the counter from the start value, so one period spans start+1 ticks.
- R6: Status bit 0 becomes 1 on the tick that moves the counter from 1 to 0, and stays set until it is cleared.
- R7: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. An event in the same cycle as a clear wins.
- R8: Output irq equals the AND of status bit 0 and control bit 2, registered, so it follows either input by one clock.
- R9: Only control bits 0, 1, 2 and 15:8 store data. All other control bits read as zero.
- R10: After reset, every register reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the clock edge on which it is presented, and read data is valid in the same cycle as the access. The bench therefore drives on the falling edge and samples just after it. Once the enabling write lands, the count has made floor(k/(P+1)) steps after k further edges, and the bench derives every expected count from that formula. The status flag rises at the edge of the final tick and irq one edge later. The bench counts edges from the triggering write and samples irq at both the first and the second falling edge, which shows the one-clock lag. The set-versus-clear collision is produced by timing the clear write onto exactly the edge of the zero tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned TMR_DATA_W = 32;
  localparam int unsigned TMR_PRE_W  = 8;
  localparam int unsigned TMR_ADDR_W = 8;

  // control word bit positions
  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_AUTO_BIT = 1;
  localparam int unsigned CTL_IE_BIT   = 2;
  localparam int unsigned CTL_DIV_LSB  = 8;

  // register select, equal to byte offset bits [3:2]
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_LIVE   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = TMR_DATA_W,
  parameter int unsigned PRE_W  = TMR_PRE_W,
  parameter int unsigned ADDR_W = TMR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] live_cnt,
  input  logic              zero_evt,
  output logic [DATA_W-1:0] start_val,
  output logic              start_wr,
  output logic              ctl_run,
  output logic              ctl_auto,
  output logic              ctl_ie,
  output logic [PRE_W-1:0]  ctl_div,
  output logic              evt_flag
);

  localparam int unsigned HI_LSB = 4;

  logic     hit;
  reg_sel_e sel;
  logic     wr_ctrl;
  logic     wr_status;

  logic [DATA_W-1:0] start_q, start_d;
  logic              run_q, run_d;
  logic              auto_q, auto_d;
  logic              ie_q, ie_d;
  logic [PRE_W-1:0]  div_q, div_d;
  logic              flag_q, flag_d;
  logic              ctrl_ce, start_ce;

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] status_word;

  // address decode
  always_comb begin
    hit = bus_en && (bus_addr[ADDR_W-1:HI_LSB] == '0) && (bus_addr[1:0] == 2'b00);
    sel = reg_sel_e'(bus_addr[3:2]);
    start_wr  = hit && bus_we && (sel == SEL_START);
    wr_ctrl   = hit && bus_we && (sel == SEL_CTRL);
    wr_status = hit && bus_we && (sel == SEL_STATUS);
  end

  // next state
  always_comb begin
    start_ce = start_wr;
    start_d  = bus_wdata;
    ctrl_ce  = wr_ctrl;
    run_d    = bus_wdata[CTL_RUN_BIT];
    auto_d   = bus_wdata[CTL_AUTO_BIT];
    ie_d     = bus_wdata[CTL_IE_BIT];
    div_d    = bus_wdata[CTL_DIV_LSB +: PRE_W];
    // event set outranks write-one clear
    flag_d = flag_q;
    if (wr_status && bus_wdata[0]) begin
      flag_d = 1'b0;
    end
    if (zero_evt) begin
      flag_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      run_q   <= 1'b0;
      auto_q  <= 1'b0;
      ie_q    <= 1'b0;
      div_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (start_ce) begin
        start_q <= start_d;
      end
      if (ctrl_ce) begin
        run_q  <= run_d;
        auto_q <= auto_d;
        ie_q   <= ie_d;
        div_q  <= div_d;
      end
      flag_q <= flag_d;
    end
  end

  // read data
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_RUN_BIT]  = run_q;
    ctrl_word[CTL_AUTO_BIT] = auto_q;
    ctrl_word[CTL_IE_BIT]   = ie_q;
    ctrl_word[CTL_DIV_LSB +: PRE_W] = div_q;
    status_word    = '0;
    status_word[0] = flag_q;
    bus_rdata = '0;
    if (hit && !bus_we) begin
      unique case (sel)
        SEL_START:  bus_rdata = start_q;
        SEL_LIVE:   bus_rdata = live_cnt;
        SEL_CTRL:   bus_rdata = ctrl_word;
        SEL_STATUS: bus_rdata = status_word;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign start_val = start_q;
  assign ctl_run   = run_q;
  assign ctl_auto  = auto_q;
  assign ctl_ie    = ie_q;
  assign ctl_div   = div_q;
  assign evt_flag  = flag_q;

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_status && bus_wdata[0])) |=> flag_q); // R6

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(run_q) && $stable(div_q) && $stable(ie_q))); // R9

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W = TMR_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q, phase_d;

  always_comb begin
    tick = run && !restart && (phase_q >= div);
    if (!run || restart || tick) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  AST_IDLE_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0)); // R3

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0)); // R2

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = TMR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              auto_rl,
  input  logic [DATA_W-1:0] refill_val,
  output logic [DATA_W-1:0] cnt,
  output logic              zero_evt
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              at_zero;

  always_comb begin
    at_zero  = (cnt_q == '0);
    zero_evt = tick && !load && (cnt_q == ONE);
    cnt_d    = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (at_zero) begin
        cnt_d = auto_rl ? refill_val : '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_LOAD_PRESETS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q)); // R3

  AST_ONESHOT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && !auto_rl) |=> (cnt_q == '0)); // R4

  AST_EVENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt_q == '0)); // R6

  AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && auto_rl) |=> (cnt_q == $past(refill_val))); // R5

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = TMR_DATA_W,
  parameter int unsigned PRE_W  = TMR_PRE_W,
  parameter int unsigned ADDR_W = TMR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic              rst_i_n;
  logic [DATA_W-1:0] live_cnt;
  logic              zero_evt;
  logic [DATA_W-1:0] start_val;
  logic              start_wr;
  logic              ctl_run, ctl_auto, ctl_ie;
  logic [PRE_W-1:0]  ctl_div;
  logic              evt_flag;
  logic              tick;
  logic              irq_q, irq_d;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tmr_regs #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .live_cnt  (live_cnt),
    .zero_evt  (zero_evt),
    .start_val (start_val),
    .start_wr  (start_wr),
    .ctl_run   (ctl_run),
    .ctl_auto  (ctl_auto),
    .ctl_ie    (ctl_ie),
    .ctl_div   (ctl_div),
    .evt_flag  (evt_flag)
  );

  tmr_prescaler #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (ctl_run),
    .restart (start_wr),
    .div     (ctl_div),
    .tick    (tick)
  );

  tmr_counter #(
    .DATA_W (DATA_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load       (start_wr),
    .load_val   (bus_wdata),
    .tick       (tick),
    .auto_rl    (ctl_auto),
    .refill_val (start_val),
    .cnt        (live_cnt),
    .zero_evt   (zero_evt)
  );

  always_comb begin
    irq_d = evt_flag && ctl_ie;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> (irq_q == $past(evt_flag && ctl_ie))); // R8

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctl_ie |=> !irq_q); // R8

endmodule

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk;
  int n_bad;

  cdt_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [7:0] A_START  = 8'h00;
  localparam logic [7:0] A_LIVE   = 8'h04;
  localparam logic [7:0] A_CTRL   = 8'h08;
  localparam logic [7:0] A_STATUS = 8'h0C;

  // vector table: start value, divide field, auto flag, edges waited
  localparam int NV = 7;
  localparam int V_START [NV] = '{5, 5, 4, 3, 2, 10, 1};
  localparam int V_DIV   [NV] = '{0, 0, 2, 1, 0, 63, 3};
  localparam int V_AUTO  [NV] = '{0, 0, 0, 1, 1, 0, 1};
  localparam int V_WAIT  [NV] = '{3, 9, 7, 12, 7, 200, 5};

  function automatic logic [31:0] exp_cnt(int r, int p, int a, int k);
    int t;
    t = k / (p + 1);
    if (t <= r) return 32'(r - t);
    if (a == 0) return 32'd0;
    return 32'(r - ((t - r - 1) % (r + 1)));
  endfunction

  function automatic logic exp_flag(int r, int p, int k);
    int t;
    t = k / (p + 1);
    return (r > 0) && (t >= r);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // caller is at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    bus_en    = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    bus_en   = 1'b1;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic edges(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    bus_en = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    edges(4);
    rst_n = 1'b1;
    edges(4);

    // R10 reset state
    rd(A_START, v);  check("R10 start", v, 32'h0);
    rd(A_LIVE, v);   check("R10 live", v, 32'h0);
    rd(A_CTRL, v);   check("R10 ctrl", v, 32'h0);
    rd(A_STATUS, v); check("R10 status", v, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 32'h0);
      wr(A_STATUS, 32'h1);
      wr(A_START, 32'(V_START[i]));
      wr(A_CTRL, 32'((V_DIV[i] << 8) | (V_AUTO[i] << 1) | 1));
      edges(V_WAIT[i] - 1);
      rd(A_LIVE, v);
      check($sformatf("R3/R4/R5 vec%0d count", i), v,
            exp_cnt(V_START[i], V_DIV[i], V_AUTO[i], V_WAIT[i] - 1));
      rd(A_STATUS, v);
      check($sformatf("R6 vec%0d flag", i), v,
            {31'b0, exp_flag(V_START[i], V_DIV[i], V_WAIT[i] - 1)});
    end

    // R1 R9: readback, read-only live, unused bits, bad offset
    wr(A_CTRL, 32'h0);
    wr(A_START, 32'hDEAD_BEEF);
    rd(A_START, v); check("R1 start readback", v, 32'hDEAD_BEEF);
    rd(A_LIVE, v);  check("R2 live preset", v, 32'hDEAD_BEEF);
    wr(A_LIVE, 32'h1234_5678);
    rd(A_LIVE, v);  check("R1 live write ignored", v, 32'hDEAD_BEEF);
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, v);  check("R9 ctrl mask", v, 32'h0000_FF00);
    rd(8'h10, v);   check("R1 unmapped read", v, 32'h0);
    rd(A_LIVE, v);  check("R3 disabled hold", v, 32'hDEAD_BEEF);

    // R8 irq timing, R7 clear-by-one
    wr(A_CTRL, 32'h0);
    wr(A_STATUS, 32'h1);
    wr(A_START, 32'd3);
    wr(A_CTRL, 32'h5);          // run + irq enable, divide 1
    edges(2);                   // 3rd tick lands on the next edge
    @(negedge clk);
    rd(A_STATUS, v); check("R6 flag at zero", v, 32'h1);
    check("R8 irq one clock later", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, v); check("R7 write zero no effect", v, 32'h1);
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, v); check("R7 write one clears", v, 32'h0);
    check("R8 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    // R7 set wins against a same-cycle clear
    wr(A_CTRL, 32'h0);
    wr(A_STATUS, 32'h1);
    wr(A_START, 32'd3);
    wr(A_CTRL, 32'h1);
    edges(2);
    wr(A_STATUS, 32'h1);        // lands on the zero tick edge
    rd(A_STATUS, v); check("R7 set beats clear", v, 32'h1);
    rd(A_LIVE, v);   check("R4 at zero", v, 32'h0);
    check("R8 no irq when disabled", {31'b0, irq}, 32'h0);

    // R2 start write mid-run restarts prescaler phase
    wr(A_CTRL, 32'h0);
    wr(A_START, 32'd20);
    wr(A_CTRL, 32'h0000_0301); // divide by 4
    edges(2);
    wr(A_START, 32'd10);
    edges(3);
    rd(A_LIVE, v); check("R2 phase restarted", v, 32'd10);
    @(negedge clk);
    rd(A_LIVE, v); check("R2 first step after restart", v, 32'd9);

    finish_run();
  end

endmodule